// File: doc/BRIEF.md
# Privilege-Based Memory Access Checker

This block rules on whether a single memory access may go ahead. A load/store or fetch unit presents the access kind (data read, data write or instruction fetch), the current processor privilege, a flag that marks the forced-unprivileged load/store variants, and the permission attributes of the target region. The region has already been selected upstream. The block answers one clock later with exactly one of three outcomes: the access is granted, it raises a data abort, or it raises a prefetch abort. A 3-bit fault-type code comes with the outcome, so the fault can be reported.

Each region carries three 2-bit permission fields: one for reading, one for writing and one for executing. It also carries a secure-region flag. Data accesses are judged against the read or the write field only, chosen by direction. They use the effective privilege, which the forced-unprivileged flag can lower. A fetch is judged by the processor mode alone, and it needs both the execute field and the read field to allow it. When the design is built with the security check enabled, a non-secure requester that touches a secure region is always refused.

Top module: `priv_access_checker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_grant`, `rsp_dabort`, `rsp_pabort` and `rsp_fault` are all zero.
- R2: `rsp_valid` is high in the cycle after `req_valid` was sampled high, and low otherwise. While `rsp_valid` is low, grant, both aborts and the fault code are zero.
- R3: A permission field is coded 2'b00 = no access, 2'b01 = privileged only, 2'b11 = everyone. The reserved code 2'b10 denies every requester.
- R4: A data access counts as privileged only when `mode_priv` is 1 and `force_unpriv` is 0.
- R5: A data read (`req_fetch`=0, `req_write`=0) consults only `perm_read`. A data write (`req_fetch`=0, `req_write`=1) consults only `perm_write`.
- R6: For a fetch (`req_fetch`=1), `force_unpriv` and `req_write` have no effect, and the privilege is `mode_priv` alone.
- R7: A fetch is granted only when both `perm_exec` and `perm_read` allow it at the fetch privilege.
- R8: A refused data access raises `rsp_dabort`, with fault code 3'b001 for a read and 3'b010 for a write.
- R9: A refused fetch raises `rsp_pabort`, with fault code 3'b011 when the cause is a permission.
- R10: With `SEC_EXT`=1, a request with `region_secure`=1 and `req_nonsecure`=1 is refused with fault code 3'b100, whatever the permissions are. The abort follows the access kind. With `SEC_EXT`=0 these two inputs have no effect.
- R11: When `rsp_valid` is high, exactly one of `rsp_grant`, `rsp_dabort` and `rsp_pabort` is high.
- R12: A granted access reports fault code 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_write | input | 1 | Data direction, 1 = write (ignored for fetches) |
| mode_priv | input | 1 | Processor is in a privileged mode |
| force_unpriv | input | 1 | Forced-unprivileged load/store variant |
| perm_read | input | 2 | Region read permission |
| perm_write | input | 2 | Region write permission |
| perm_exec | input | 2 | Region execute permission |
| region_secure | input | 1 | Region is marked secure |
| req_nonsecure | input | 1 | Requester is in the non-secure state |
| rsp_valid | output | 1 | Verdict valid |
| rsp_grant | output | 1 | Access permitted |
| rsp_dabort | output | 1 | Data abort |
| rsp_pabort | output | 1 | Prefetch abort |
| rsp_fault | output | 3 | Fault type: 0 none, 1 read, 2 write, 3 execute, 4 security |

## Verification
The bench builds two copies side by side on the same stimulus. One has `SEC_EXT`=1, so the secure-region refusal and its priority over the permission faults can be observed. The other has `SEC_EXT`=0, which shows that the two security inputs are then inert. An exhaustive sweep covers every combination of access kind, mode, forced-unprivileged flag, the three permission codes (the reserved one included) and the security flags. Idle cycles are interleaved with the requests, so both the one-cycle latency and the cleared outputs between requests are observed.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int PERM_W  = 2;
    localparam int FAULT_W = 3;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE = 2'b00,
        PERM_PRIV = 2'b01,
        PERM_RSVD = 2'b10,
        PERM_ALL  = 2'b11
    } perm_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE  = 3'd0,
        FLT_READ  = 3'd1,
        FLT_WRITE = 3'd2,
        FLT_EXEC  = 3'd3,
        FLT_SEC   = 3'd4
    } fault_e;

    typedef struct packed {
        logic   grant;
        logic   dabort;
        logic   pabort;
        fault_e fault;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{grant: 1'b0, dabort: 1'b0,
                                          pabort: 1'b0, fault: FLT_NONE};

    function automatic logic perm_allows(input logic [PERM_W-1:0] code,
                                         input logic is_priv);
        logic ok;
        case (perm_e'(code))
            PERM_ALL:  ok = 1'b1;
            PERM_PRIV: ok = is_priv;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/acc_priv_resolve.sv
module acc_priv_resolve (
    input  logic mode_priv,
    input  logic force_unpriv,
    output logic data_priv,
    output logic fetch_priv
);
    always_comb begin
        data_priv  = mode_priv & ~force_unpriv;
        fetch_priv = mode_priv;
    end
endmodule

// File: rtl/acc_perm_eval.sv
module acc_perm_eval
    import acc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0][PERM_W-1:0] codes,
    input  logic [LANES-1:0]             privs,
    output logic [LANES-1:0]             allow
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb allow[g] = perm_allows(codes[g], privs[g]);
    end
endmodule

// File: rtl/acc_verdict.sv
module acc_verdict
    import acc_pkg::*;
#(
    parameter bit SEC_EXT = 1'b1
) (
    input  logic     is_fetch,
    input  logic     is_write,
    input  logic     rd_ok,
    input  logic     wr_ok,
    input  logic     ex_ok,
    input  logic     rd_fetch_ok,
    input  logic     region_secure,
    input  logic     req_nonsecure,
    output verdict_t verdict
);
    logic sec_block;

    if (SEC_EXT) begin : g_sec
        assign sec_block = region_secure & req_nonsecure;
    end else begin : g_nosec
        logic unused_sec;
        assign unused_sec = region_secure ^ req_nonsecure;
        assign sec_block  = 1'b0;
    end

    logic data_ok;
    logic fetch_ok;

    always_comb begin
        data_ok  = is_write ? wr_ok : rd_ok;
        fetch_ok = ex_ok & rd_fetch_ok;
        verdict  = VERDICT_IDLE;
        if (sec_block) begin
            verdict.fault = FLT_SEC;
            if (is_fetch) verdict.pabort = 1'b1;
            else          verdict.dabort = 1'b1;
        end else if (is_fetch) begin
            if (fetch_ok) begin
                verdict.grant = 1'b1;
            end else begin
                verdict.pabort = 1'b1;
                verdict.fault  = FLT_EXEC;
            end
        end else begin
            if (data_ok) begin
                verdict.grant = 1'b1;
            end else begin
                verdict.dabort = 1'b1;
                verdict.fault  = is_write ? FLT_WRITE : FLT_READ;
            end
        end
    end
endmodule

// File: rtl/priv_access_checker.sv
module priv_access_checker
    import acc_pkg::*;
#(
    parameter bit SEC_EXT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_fetch,
    input  logic               req_write,
    input  logic               mode_priv,
    input  logic               force_unpriv,
    input  logic [PERM_W-1:0]  perm_read,
    input  logic [PERM_W-1:0]  perm_write,
    input  logic [PERM_W-1:0]  perm_exec,
    input  logic               region_secure,
    input  logic               req_nonsecure,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_dabort,
    output logic               rsp_pabort,
    output logic [FAULT_W-1:0] rsp_fault
);
    localparam int LANES = 4;

    logic data_priv;
    logic fetch_priv;

    acc_priv_resolve u_priv (
        .mode_priv   (mode_priv),
        .force_unpriv(force_unpriv),
        .data_priv   (data_priv),
        .fetch_priv  (fetch_priv)
    );

    // lanes: 0 read/data, 1 write/data, 2 exec/fetch, 3 read/fetch
    logic [LANES-1:0][PERM_W-1:0] lane_code;
    logic [LANES-1:0]             lane_priv;
    logic [LANES-1:0]             lane_ok;

    always_comb begin
        lane_code[0] = perm_read;
        lane_code[1] = perm_write;
        lane_code[2] = perm_exec;
        lane_code[3] = perm_read;
        lane_priv    = {fetch_priv, fetch_priv, data_priv, data_priv};
    end

    acc_perm_eval #(.LANES(LANES)) u_eval (
        .codes(lane_code),
        .privs(lane_priv),
        .allow(lane_ok)
    );

    verdict_t next_verdict;

    acc_verdict #(.SEC_EXT(SEC_EXT)) u_verdict (
        .is_fetch     (req_fetch),
        .is_write     (req_write),
        .rd_ok        (lane_ok[0]),
        .wr_ok        (lane_ok[1]),
        .ex_ok        (lane_ok[2]),
        .rd_fetch_ok  (lane_ok[3]),
        .region_secure(region_secure),
        .req_nonsecure(req_nonsecure),
        .verdict      (next_verdict)
    );

    verdict_t verdict_q;
    logic     valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= VERDICT_IDLE;
        end else begin
            valid_q   <= req_valid;
            verdict_q <= req_valid ? next_verdict : VERDICT_IDLE;
        end
    end

    always_comb begin
        rsp_valid  = valid_q;
        rsp_grant  = verdict_q.grant;
        rsp_dabort = verdict_q.dabort;
        rsp_pabort = verdict_q.pabort;
        rsp_fault  = verdict_q.fault;
    end
endmodule

// File: rtl/priv_access_checker_sva.sv
module priv_access_checker_sva #(
    parameter bit SEC_EXT = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_fetch,
    input logic       region_secure,
    input logic       req_nonsecure,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic       rsp_dabort,
    input logic       rsp_pabort,
    input logic [2:0] rsp_fault
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_dabort && !rsp_pabort && rsp_fault == 3'd0));
    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_grant, rsp_dabort, rsp_pabort}));
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_grant, rsp_dabort, rsp_pabort}) == 1);
    assert_grant_code_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_grant |-> rsp_fault == 3'd0);
    assert_fetch_no_dabort_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fetch) |=> !rsp_dabort);
    assert_data_no_pabort_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_fetch) |=> !rsp_pabort);
    assert_pabort_code_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_pabort |-> (rsp_fault == 3'd3 || rsp_fault == 3'd4));
    assert_dabort_code_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_dabort |-> (rsp_fault == 3'd1 || rsp_fault == 3'd2 || rsp_fault == 3'd4));
    assert_secure_block_R10: assert property (@(posedge clk) disable iff (rst)
        (SEC_EXT && req_valid && region_secure && req_nonsecure) |=> (!rsp_grant && rsp_fault == 3'd4));
endmodule

bind priv_access_checker priv_access_checker_sva #(.SEC_EXT(SEC_EXT)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_fetch    (req_fetch),
    .region_secure(region_secure),
    .req_nonsecure(req_nonsecure),
    .rsp_valid    (rsp_valid),
    .rsp_grant    (rsp_grant),
    .rsp_dabort   (rsp_dabort),
    .rsp_pabort   (rsp_pabort),
    .rsp_fault    (rsp_fault)
);

// File: tb/sim_priv_access_checker.sv
`timescale 1ns/1ps
module sim_priv_access_checker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
    logic       mode_priv = 1'b0, force_unpriv = 1'b0;
    logic [1:0] perm_read = 2'b00, perm_write = 2'b00, perm_exec = 2'b00;
    logic       region_secure = 1'b0, req_nonsecure = 1'b0;

    logic       v0, g0, d0, p0, v1, g1, d1, p1;
    logic [2:0] f0, f1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    priv_access_checker #(.SEC_EXT(1'b1)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_fetch(req_fetch),
        .req_write(req_write), .mode_priv(mode_priv), .force_unpriv(force_unpriv),
        .perm_read(perm_read), .perm_write(perm_write), .perm_exec(perm_exec),
        .region_secure(region_secure), .req_nonsecure(req_nonsecure),
        .rsp_valid(v0), .rsp_grant(g0), .rsp_dabort(d0), .rsp_pabort(p0), .rsp_fault(f0));

    priv_access_checker #(.SEC_EXT(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_fetch(req_fetch),
        .req_write(req_write), .mode_priv(mode_priv), .force_unpriv(force_unpriv),
        .perm_read(perm_read), .perm_write(perm_write), .perm_exec(perm_exec),
        .region_secure(region_secure), .req_nonsecure(req_nonsecure),
        .rsp_valid(v1), .rsp_grant(g1), .rsp_dabort(d1), .rsp_pabort(p1), .rsp_fault(f1));

    // Reference: returns {valid, grant, dabort, pabort, fault[2:0]}
    function automatic logic [6:0] model(input bit sec_en, input bit v, input bit f,
            input bit w, input bit pm, input bit fu, input bit [1:0] r,
            input bit [1:0] wr, input bit [1:0] ex, input bit s, input bit ns);
        int  lvl_r, lvl_w, lvl_x;
        bit  who_priv;
        bit  ok;
        if (!v) return 7'b0;
        lvl_r = (r == 2'b11) ? 2 : (r == 2'b01) ? 1 : 0;
        lvl_w = (wr == 2'b11) ? 2 : (wr == 2'b01) ? 1 : 0;
        lvl_x = (ex == 2'b11) ? 2 : (ex == 2'b01) ? 1 : 0;
        if (sec_en && s && ns) return f ? 7'b1001100 : 7'b1010100;
        if (f) begin
            who_priv = pm;
            ok = (lvl_x == 2 || (lvl_x == 1 && who_priv)) &&
                 (lvl_r == 2 || (lvl_r == 1 && who_priv));
            return ok ? 7'b1100000 : 7'b1001011;
        end
        who_priv = pm && !fu;
        if (w) begin
            ok = lvl_w == 2 || (lvl_w == 1 && who_priv);
            return ok ? 7'b1100000 : 7'b1010010;
        end
        ok = lvl_r == 2 || (lvl_r == 1 && who_priv);
        return ok ? 7'b1100000 : 7'b1010001;
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual={v%b g%b d%b p%b f%0d} expected={v%b g%b d%b p%b f%0d}",
                     tag, act[6], act[5], act[4], act[3], act[2:0],
                     exp[6], exp[5], exp[4], exp[3], exp[2:0]);
        end
    endtask

    // Drive at a negedge, let one posedge register it, compare at the next negedge.
    task automatic step(input string tag, input bit v, input bit f, input bit w,
            input bit pm, input bit fu, input bit [1:0] r, input bit [1:0] wr,
            input bit [1:0] ex, input bit s, input bit ns);
        logic [6:0] e0, e1;
        req_valid = v; req_fetch = f; req_write = w; mode_priv = pm; force_unpriv = fu;
        perm_read = r; perm_write = wr; perm_exec = ex; region_secure = s; req_nonsecure = ns;
        e0 = model(1'b1, v, f, w, pm, fu, r, wr, ex, s, ns);
        e1 = model(1'b0, v, f, w, pm, fu, r, wr, ex, s, ns);
        @(posedge clk);
        @(negedge clk);
        check({tag, " u0"}, {v0, g0, d0, p0, f0}, e0);
        check({tag, " u1"}, {v1, g1, d1, p1, f1}, e1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset u0", {v0, g0, d0, p0, f0}, 7'b0);
        check("R1 in reset u1", {v1, g1, d1, p1, f1}, 7'b0);
        req_valid = 1'b0;
        rst = 1'b0;
        step("R1 after reset", 0, 0, 0, 1, 0, 2'b11, 2'b11, 2'b11, 0, 0);

        step("R3 rd all unpriv",      1, 0, 0, 0, 0, 2'b11, 2'b00, 2'b00, 0, 0);
        step("R3 rd priv-only user",  1, 0, 0, 0, 0, 2'b01, 2'b11, 2'b11, 0, 0);
        step("R3 rd reserved priv",   1, 0, 0, 1, 0, 2'b10, 2'b11, 2'b11, 0, 0);
        step("R4 forced unpriv read", 1, 0, 0, 1, 1, 2'b01, 2'b11, 2'b11, 0, 0);
        step("R4 priv read ok",       1, 0, 0, 1, 0, 2'b01, 2'b00, 2'b00, 0, 0);
        step("R5 write ignores rd",   1, 0, 1, 0, 0, 2'b00, 2'b11, 2'b00, 0, 0);
        step("R5 write denied R8",    1, 0, 1, 1, 1, 2'b11, 2'b01, 2'b11, 0, 0);
        step("R6 fetch ignores force",1, 1, 1, 1, 1, 2'b01, 2'b00, 2'b01, 0, 0);
        step("R7 fetch rd denies R9", 1, 1, 0, 1, 0, 2'b00, 2'b11, 2'b11, 0, 0);
        step("R7 fetch ex denies",    1, 1, 0, 0, 0, 2'b11, 2'b11, 2'b01, 0, 0);
        step("R10 secure data",       1, 0, 0, 1, 0, 2'b11, 2'b11, 2'b11, 1, 1);
        step("R10 secure fetch",      1, 1, 0, 1, 0, 2'b11, 2'b11, 2'b11, 1, 1);
        step("R10 secure from secure",1, 0, 1, 1, 0, 2'b11, 2'b11, 2'b11, 1, 0);
        step("R2 idle cycle",         0, 1, 0, 0, 0, 2'b00, 2'b00, 2'b00, 1, 1);
        step("R2 back-to-back a R12", 1, 0, 0, 0, 0, 2'b11, 2'b00, 2'b00, 0, 0);
        step("R2 back-to-back b R11", 1, 0, 1, 0, 0, 2'b11, 2'b00, 2'b00, 0, 0);

        for (int k = 0; k < 4096; k++) begin
            logic [11:0] b;
            b = k[11:0];
            step("sweep", 1, b[0], b[1], b[2], b[3], b[5:4], b[7:6], b[9:8], b[10], b[11]);
            step("sweep idle R2", 0, b[1], b[0], b[3], b[2], b[9:8], b[5:4], b[7:6], b[11], b[10]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule